// File: doc/BRIEF.md
# Streaming Serial Register-File Slave

This block lets an external serial master read and write a small byte-wide register file inside the chip. The master pulls chip select low and shifts in a header: a direction bit, then a 15-bit register address. After the header it moves data bytes for as long as chip select stays low. The first byte goes to or comes from the header address. After every byte the address moves by one, up or down as a configuration bit selects, so one transfer can cover a whole run of registers.

The serial pins are oversampled in the system clock domain. Input bits are taken on the rising serial-clock edge. Read bits are launched on the falling edge, so the master can sample them on the next rising edge. Read data can come back on the shared data line (3-wire, the reset mode) or on a dedicated output (4-wire), and the mode can be changed at run time. Each output pin has its own enable, and pad logic outside the block uses these enables to turn the pins around.

Two configuration registers control the interface. A self-clearing software reset returns the general registers to their defaults and leaves both configuration registers alone. The active-low hardware reset restores everything. The general registers are also presented in parallel to the rest of the chip.

Top module: `spi_regfile_slave`

## Requirements
- R1: After chip select falls, the first bit sampled on a rising serial-clock edge is the direction bit (0 = write, 1 = read). It is followed by a 15-bit address, most significant bit first, and then 8-bit data bytes, most significant bit first.
- R2: While chip select stays low, data bytes follow one another without limit. The first byte uses the header address, and each later byte uses the address after the previous step.
- R3: After each complete data byte the address moves by +1 when bit 2 of configuration register A (address 0x0000) is 0, and by -1 when that bit is 1. The address wraps modulo 2^15.
- R4: In 3-wire mode, read data appears on `spi_sdio_o` and changes only after a falling serial-clock edge. `spi_sdio_oe` stays low during the whole header, rises only after the last address bit has been sampled, and falls once chip select goes high.
- R5: When bit 1 of configuration register A is 1, read data appears on `spi_sdo` under `spi_sdo_oe`, and `spi_sdio_oe` stays low.
- R6: Writing 1 to bit 0 of configuration register A returns the eight general registers (addresses 0x0010 to 0x0017, default 0xA0 plus the register index) to their defaults. Configuration register A bits 2:1 and configuration register B (address 0x0001) keep their values. Bit 0 clears itself and reads back as 0.
- R7: While `rst_n` is low, every register returns to its default: configuration registers A and B become 0x00, which means 3-wire mode and ascending addresses, and the general registers become 0xA0 plus the register index.
- R8: If chip select goes high partway through a byte, that byte is discarded and no register changes. Earlier complete bytes in the same transfer stay written.
- R9: Addresses outside 0x0000, 0x0001 and 0x0010 to 0x0017 read as 0x00 and ignore writes. The address still steps past them as usual.
- R10: `reg_q` carries general register i on bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdio_i | input | 1 | Serial data in (the input side of the shared data line) |
| spi_sdio_o | output | 1 | Read data for the shared data line |
| spi_sdio_oe | output | 1 | Drive enable for the shared data line (3-wire reads) |
| spi_sdo | output | 1 | Read data for the dedicated output pin |
| spi_sdo_oe | output | 1 | Drive enable for the dedicated output pin (4-wire reads) |
| reg_q | output | 8*NUM_GEN | Parallel view of the general registers |

## Verification
The bench goes after the points where a stream meets the edge of the map. A run that steps off the last general register must return zero and still advance. A descending run must wrap from address 0x0000 down to 0x7FFF, and a design that saturated or stalled the counter would echo the same register twice. It aborts transfers both inside the first byte and inside a later byte of a stream. This catches a design that commits a partial byte, and also one that throws away bytes already complete. It then fires the software reset while the block is in 4-wire mode: if the reset also cleared configuration register A, read data would jump back to the shared line and the next read would come back empty. Throughout, it watches that the shared-line enable stays off for the whole header and that the unused pin is never enabled.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int ADDR_W   = 15;
  localparam int BYTE_W   = 8;
  localparam int HDR_BITS = 1 + ADDR_W;

  localparam logic [ADDR_W-1:0] CFG_A_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CFG_B_ADDR = ADDR_W'(1);

  localparam int CFGA_SRST_BIT = 0;
  localparam int CFGA_4W_BIT   = 1;
  localparam int CFGA_DESC_BIT = 2;

  typedef enum logic {
    PH_HDR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  function automatic logic [BYTE_W-1:0] gen_default(input int unsigned idx);
    return BYTE_W'(32'hA0 + idx);
  endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_n_s,
  output logic mosi_s
);
  // bundle order {sclk, cs_n, mosi}; chip select idles high
  localparam logic [2:0] IDLE = 3'b010;

  logic [2:0] chain [SYNC_STAGES];
  logic       sclk_d;
  logic [2:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= IDLE;
      sclk_d <= 1'b0;
    end else begin
      chain[0] <= {sclk, cs_n, mosi};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      sclk_d <= last[2];
    end
  end

  assign last      = chain[SYNC_STAGES-1];
  assign sclk_rise =  last[2] & ~sclk_d;
  assign sclk_fall = ~last[2] &  sclk_d;
  assign cs_n_s    = last[1];
  assign mosi_s    = last[0];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              step_down,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_dir,
  output logic              data_phase,
  output logic              miso
);
  localparam int HCNT_W = $clog2(HDR_BITS);
  localparam int DCNT_W = $clog2(BYTE_W);
  localparam logic [HCNT_W-1:0] HDR_LAST = HCNT_W'(HDR_BITS - 1);
  localparam logic [DCNT_W-1:0] BIT_LAST = DCNT_W'(BYTE_W - 1);

  phase_e            phase;
  logic [HCNT_W-1:0] hcnt;
  logic [DCNT_W-1:0] dcnt;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-2:0] dsh;
  logic [BYTE_W-1:0] rbyte;
  logic              miso_q;

  logic              rise_ok, fall_ok, byte_done;
  logic [ADDR_W-1:0] next_addr;

  assign rise_ok   = sclk_rise & ~cs_n_s;
  assign fall_ok   = sclk_fall & ~cs_n_s;
  assign byte_done = rise_ok && (phase == PH_DATA) && (dcnt == BIT_LAST);
  assign next_addr = step_down ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HDR;
      hcnt    <= '0;
      dcnt    <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
      dsh     <= '0;
      rbyte   <= '0;
      miso_q  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (cs_n_s) begin
      phase  <= PH_HDR;
      hcnt   <= '0;
      dcnt   <= '0;
      miso_q <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rise_ok) begin
        if (phase == PH_HDR) begin
          if (hcnt == '0) rw_q <= mosi_s;
          else            addr_q <= {addr_q[ADDR_W-2:0], mosi_s};
          if (hcnt == HDR_LAST) begin
            phase <= PH_DATA;
            dcnt  <= '0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end else if (dcnt == BIT_LAST) begin
          dcnt   <= '0;
          addr_q <= next_addr;
          if (!rw_q) begin
            wr_en   <= 1'b1;
            wr_addr <= addr_q;
            wr_data <= {dsh, mosi_s};
          end
        end else begin
          dcnt <= dcnt + 1'b1;
          dsh  <= {dsh[BYTE_W-3:0], mosi_s};
        end
      end
      if (fall_ok && phase == PH_DATA && rw_q) begin
        if (dcnt == '0) begin
          rbyte  <= rd_byte;
          miso_q <= rd_byte[BYTE_W-1];
        end else begin
          miso_q <= rbyte[BIT_LAST - dcnt];
        end
      end
    end
  end

  assign cur_addr   = addr_q;
  assign rd_dir     = rw_q;
  assign data_phase = (phase == PH_DATA);
  assign miso       = miso_q;

  // R2: a byte takes many system cycles, so write strobes never touch
  a_r2_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: once chip select is seen high no write may follow
  a_r8_no_write_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !wr_en);

  // R3: the address moves by exactly one in the configured direction
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> addr_q == ($past(step_down) ? $past(addr_q) - ADDR_W'(1)
                                              : $past(addr_q) + ADDR_W'(1)));

  // R4: read data only changes on a falling serial-clock edge
  a_r4_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_ok && !cs_n_s) |=> $stable(miso_q));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rf_pkg::*;
#(
  parameter int NUM_GEN  = 8,
  parameter int GEN_BASE = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [BYTE_W-1:0]         rd_data,
  output logic                      four_wire,
  output logic                      step_down,
  output logic [NUM_GEN*BYTE_W-1:0] gen_flat
);
  logic              srst_q;
  logic              four_wire_q;
  logic              desc_q;
  logic [BYTE_W-1:0] cfg_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q      <= 1'b0;
      four_wire_q <= 1'b0;
      desc_q      <= 1'b0;
      cfg_b_q     <= '0;
    end else begin
      srst_q <= 1'b0;
      if (wr_en && wr_addr == CFG_A_ADDR) begin
        srst_q      <= wr_data[CFGA_SRST_BIT];
        four_wire_q <= wr_data[CFGA_4W_BIT];
        desc_q      <= wr_data[CFGA_DESC_BIT];
      end
      if (wr_en && wr_addr == CFG_B_ADDR) cfg_b_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(GEN_BASE + g);
    localparam logic [BYTE_W-1:0] MY_DFLT = gen_default(g);
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= MY_DFLT;
      else if (srst_q)                      q <= MY_DFLT;
      else if (wr_en && wr_addr == MY_ADDR) q <= wr_data;
    end

    assign gen_flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CFG_A_ADDR) begin
      rd_data[CFGA_SRST_BIT] = srst_q;
      rd_data[CFGA_4W_BIT]   = four_wire_q;
      rd_data[CFGA_DESC_BIT] = desc_q;
    end else if (rd_addr == CFG_B_ADDR) begin
      rd_data = cfg_b_q;
    end else begin
      for (int i = 0; i < NUM_GEN; i++)
        if (rd_addr == ADDR_W'(GEN_BASE + i)) rd_data = gen_flat[i*BYTE_W +: BYTE_W];
    end
  end

  assign four_wire = four_wire_q;
  assign step_down = desc_q;

  // R6: the soft-reset bit is high for a single cycle
  a_r6_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);

  // R6: a soft reset leaves both configuration registers alone
  a_r6_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> $stable(cfg_b_q) && $stable(four_wire_q) && $stable(desc_q));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
  import spi_rf_pkg::*;
#(
  parameter int NUM_GEN     = 8,
  parameter int GEN_BASE    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_sdio_i,
  output logic                      spi_sdio_o,
  output logic                      spi_sdio_oe,
  output logic                      spi_sdo,
  output logic                      spi_sdo_oe,
  output logic [NUM_GEN*BYTE_W-1:0] reg_q
);
  logic              sclk_rise, sclk_fall, cs_n_s, mosi_s;
  logic              step_down, four_wire;
  logic [BYTE_W-1:0] rd_byte;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic              rd_dir, data_phase, miso;
  logic              rd_active;

  spi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_sdio_i),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s)
  );

  spi_frame i_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .cs_n_s     (cs_n_s),
    .mosi_s     (mosi_s),
    .step_down  (step_down),
    .rd_byte    (rd_byte),
    .cur_addr   (cur_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_dir     (rd_dir),
    .data_phase (data_phase),
    .miso       (miso)
  );

  spi_regbank #(.NUM_GEN(NUM_GEN), .GEN_BASE(GEN_BASE)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (cur_addr),
    .rd_data   (rd_byte),
    .four_wire (four_wire),
    .step_down (step_down),
    .gen_flat  (reg_q)
  );

  assign rd_active   = data_phase & rd_dir & ~cs_n_s;
  assign spi_sdio_oe = rd_active & ~four_wire;
  assign spi_sdo_oe  = rd_active &  four_wire;
  assign spi_sdio_o  = miso;
  assign spi_sdo     = miso;

  // R4: the shared line may only start driving on a serial-clock rising edge
  a_r4_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sdio_oe) |-> $past(sclk_rise) || $past(four_wire));
endmodule

// File: tb/test_spi_regfile_slave.sv
module test_spi_regfile_slave;
  localparam int NUM_GEN = 8;
  localparam int HALF    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_sdio_i = 1'b0;
  logic spi_sdio_o, spi_sdio_oe, spi_sdo, spi_sdo_oe;
  logic [NUM_GEN*8-1:0] reg_q;

  int n_checks = 0;
  int n_fail   = 0;
  logic bench_4w = 1'b0;
  logic hdr_oe_seen, data_oe_bad;
  logic [63:0] rb;
  logic [NUM_GEN*8-1:0] dflt;

  always #2.5 clk = ~clk;

  spi_regfile_slave i_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_sdio_i(spi_sdio_i), .spi_sdio_o(spi_sdio_o), .spi_sdio_oe(spi_sdio_oe),
    .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .reg_q(reg_q)
  );

  // {address, write byte, expected read-back}
  localparam int NV = 6;
  localparam logic [30:0] VEC [NV] = '{
    {15'h0010, 8'h3C, 8'h3C},
    {15'h0017, 8'h81, 8'h81},
    {15'h0001, 8'h5A, 8'h5A},
    {15'h0018, 8'hFF, 8'h00},
    {15'h000F, 8'h12, 8'h00},
    {15'h7FFF, 8'hEE, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // data bits are left-aligned: bit 63 goes first
  task automatic spi_xfer(input logic rw, input logic [14:0] addr, input int nbits,
                          input logic [63:0] wbits, output logic [63:0] rbits);
    logic [15:0] hdr;
    hdr = {rw, addr};
    rbits = '0;
    hdr_oe_seen = 1'b0;
    data_oe_bad = 1'b0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 15; i >= 0; i--) begin
      spi_sclk = 1'b0; spi_sdio_i = hdr[i];
      repeat (HALF) @(negedge clk);
      if (spi_sdio_oe || spi_sdo_oe) hdr_oe_seen = 1'b1;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0; spi_sdio_i = wbits[63-i];
      repeat (HALF) @(negedge clk);
      rbits[63-i] = bench_4w ? spi_sdo : spi_sdio_o;
      if (rw && (bench_4w ? (spi_sdio_oe || !spi_sdo_oe) : (spi_sdo_oe || !spi_sdio_oe)))
        data_oe_bad = 1'b1;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    spi_sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr1(input logic [14:0] a, input logic [7:0] d);
    logic [63:0] r;
    spi_xfer(1'b0, a, 8, {d, 56'h0}, r);
  endtask

  task automatic rd1(input logic [14:0] a, output logic [7:0] d);
    logic [63:0] r;
    spi_xfer(1'b1, a, 8, 64'h0, r);
    d = r[63:56];
  endtask

  initial begin : main
    logic [7:0] b;
    for (int i = 0; i < NUM_GEN; i++) dflt[i*8 +: 8] = 8'(8'hA0 + i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7 R10: reset state
    chk("R7 oe low after reset", {62'h0, spi_sdio_oe, spi_sdo_oe}, 64'h0);
    chk("R10 reg_q defaults", 64'(reg_q), 64'(dflt));
    rd1(15'h0000, b); chk("R7 cfg A default", 64'(b), 64'h00);
    rd1(15'h0013, b); chk("R1 read gen3 default", 64'(b), 64'hA3);
    chk("R4 no enable in header", 64'(hdr_oe_seen), 64'h0);
    chk("R4 sdio enable during read", 64'(data_oe_bad), 64'h0);
    chk("R4 enable off after cs high", {62'h0, spi_sdio_oe, spi_sdo_oe}, 64'h0);

    // R2 R3: ascending stream read
    spi_xfer(1'b1, 15'h0010, 24, 64'h0, rb);
    chk("R2 ascending read stream", 64'(rb[63:40]), 64'hA0A1A2);

    // R1 R9: table of single writes and read-backs
    for (int v = 0; v < NV; v++) begin
      wr1(VEC[v][30:16], VEC[v][15:8]);
      rd1(VEC[v][30:16], b);
      chk("R1/R9 table write-read", 64'(b), 64'(VEC[v][7:0]));
    end
    chk("R10 reg_q byte 0", 64'(reg_q[7:0]), 64'h3C);
    chk("R10 reg_q byte 7", 64'(reg_q[63:56]), 64'h81);

    // R2: streamed write then streamed read
    spi_xfer(1'b0, 15'h0012, 24, 64'h112233_0000000000, rb);
    spi_xfer(1'b1, 15'h0012, 24, 64'h0, rb);
    chk("R2 streamed write read-back", 64'(rb[63:40]), 64'h112233);

    // R9: stream steps off the map
    spi_xfer(1'b0, 15'h0016, 24, 64'h445566_0000000000, rb);
    spi_xfer(1'b1, 15'h0016, 24, 64'h0, rb);
    chk("R9 stream past last register", 64'(rb[63:40]), 64'h445500);

    // R3: descending mode
    wr1(15'h0000, 8'h04);
    spi_xfer(1'b1, 15'h0013, 24, 64'h0, rb);
    chk("R3 descending read", 64'(rb[63:40]), 64'h2211A1);
    spi_xfer(1'b0, 15'h0015, 16, 64'h9A9B_000000000000, rb);
    spi_xfer(1'b1, 15'h0015, 16, 64'h0, rb);
    chk("R3 descending write", 64'(rb[63:48]), 64'h9A9B);
    spi_xfer(1'b1, 15'h0001, 24, 64'h0, rb);
    chk("R3 descending wrap to 0x7FFF", 64'(rb[63:40]), 64'h5A0400);

    // R5: 4-wire mode
    wr1(15'h0000, 8'h02);
    bench_4w = 1'b1;
    rd1(15'h0010, b);
    chk("R5 read on dedicated pin", 64'(b), 64'h3C);
    chk("R5 enables in 4-wire read", 64'(data_oe_bad), 64'h0);
    rd1(15'h0000, b);
    chk("R5 cfg A reads 4-wire", 64'(b), 64'h02);

    // R8: aborts
    spi_xfer(1'b0, 15'h0010, 4, 64'hF000000000000000, rb);
    rd1(15'h0010, b);
    chk("R8 partial first byte dropped", 64'(b), 64'h3C);
    spi_xfer(1'b0, 15'h0011, 12, 64'h6DF0000000000000, rb);
    spi_xfer(1'b1, 15'h0011, 16, 64'h0, rb);
    chk("R8 complete byte kept, partial dropped", 64'(rb[63:48]), 64'h6D11);

    // R6: soft reset in 4-wire mode
    wr1(15'h0001, 8'h22);
    wr1(15'h0000, 8'h03);
    spi_xfer(1'b1, 15'h0010, 64, 64'h0, rb);
    chk("R6 general registers restored", rb, 64'hA0A1A2A3A4A5A6A7);
    rd1(15'h0000, b);
    chk("R6 cfg A kept, reset bit clear", 64'(b), 64'h02);
    rd1(15'h0001, b);
    chk("R6 cfg B kept", 64'(b), 64'h22);
    chk("R6 reg_q defaults", 64'(reg_q), 64'(dflt));

    // R7: hardware reset
    wr1(15'h0014, 8'h5E);
    @(negedge clk); rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 reg_q in reset", 64'(reg_q), 64'(dflt));
    rst_n = 1'b1;
    bench_4w = 1'b0;
    repeat (4) @(negedge clk);
    rd1(15'h0001, b);
    chk("R7 cfg B cleared, 3-wire back", 64'(b), 64'h00);
    rd1(15'h0000, b);
    chk("R7 cfg A cleared", 64'(b), 64'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule